// File: doc/BRIEF.md
# Three-Wire Nibble Clock-Chip Bus Master

This block lets on-chip logic read and write the 4-bit registers of an external timekeeping chip over a three-wire serial link: a chip-select strobe, a serial clock and one shared data wire. The data wire is modelled as a split output, output-enable and input, so a pad cell outside the block forms the bidirectional pin. The host raises `req_valid` for one cycle with a direction flag, a 4-bit register number and, for writes, a 4-bit value. The block frames the command, clocks it out MSB first, and reports completion with a one-cycle `done`.

Every transfer uses 16 clock slots under one chip-select window. A write sends an address frame and then a data frame. A read sends an address frame, releases the data wire, clocks in eight bits and keeps the final four as the result. Each bit slot has three equal phases of `PHASE_CYCLES` system clocks: data setup with the serial clock high, clock low, and clock high. A whole transfer therefore takes a fixed 48 × `PHASE_CYCLES` cycles.

Top module: `rtc3w_master`

## Requirements
- R1: While reset is low and after it is released, `bus_ce` is 0, `bus_sclk` is 1, `bus_sdo` is 1, `bus_sdo_en` is 1, and `busy` and `done` are 0.
- R2: Every frame on the wire is 8 bits sent MSB first. Bit 7 is a filler driven 1, bit 6 is the direction flag (1 read, 0 write), bit 5 marks an address frame, bit 4 marks a data frame, and bits 3..0 carry the 4-bit field.
- R3: A read sends the frame 1,1,1,0,A3..A0, then clocks in eight bits. The first four are dropped and the last four, first bit as D3, appear on `rd_data`.
- R4: A write sends 1,0,1,0,A3..A0 and then 1,0,0,1,D3..D0, both under one chip-select window.
- R5: Each serial clock low phase lasts exactly `PHASE_CYCLES` cycles. `bus_sdo` stays unchanged while the clock is low and is held at least `PHASE_CYCLES` cycles before each falling clock edge.
- R6: The block samples an input bit in the last cycle of its setup phase, before that bit's clock low pulse. The external chip may therefore change the data wire after each rising clock edge.
- R7: During a read, `bus_sdo_en` drops only after the 8th rising clock edge. During a write it never drops. It is high whenever `bus_ce` is low.
- R8: `bus_ce` rises one full setup phase before the first falling clock edge and falls one high phase after the 16th rising edge. `bus_sclk` is high whenever `bus_ce` is low.
- R9: `req_valid` is ignored while `busy` is high. No extra transfer appears on the wire.
- R10: `done` is high for exactly one cycle, the cycle in which `bus_ce` has just fallen, which is 48 × `PHASE_CYCLES` cycles after the accepting edge. `rd_data` is valid in that cycle and `busy` is low in the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register number in the external chip |
| req_wdata | input | 4 | Value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 4 | Result of the last read |
| bus_ce | output | 1 | Chip-select strobe to the external chip |
| bus_sclk | output | 1 | Serial clock, idles high |
| bus_sdo | output | 1 | Data wire output value |
| bus_sdo_en | output | 1 | Data wire output enable (1 = drive) |
| bus_sdi | input | 1 | Data wire input value |

## Verification
The bound checker watches the electrical rules on every cycle: the clock idles high outside the select window, the data wire is frozen while the clock is low, every low phase has the programmed width, the data wire turns around only with select high and clock high, and `done` is a single pulse that coincides with select falling. Only the bench scenarios can show the frame contents, the dropping of the four leading input bits, the bit at which the wire turns around, the fixed latency and the rejection of requests made while busy. The bench shows these with a slave model that stores written values and answers reads with the complement nibble in front of the real data.

// File: rtl/rtc3w_pkg.sv
// Shared constants, bus phase encoding and frame layout for the
// three-wire nibble bus master. Assumes 4-bit fields and 8-bit frames.
package rtc3w_pkg;

    localparam int FRAME_BITS = 8;
    localparam int NIB_BITS   = 4;
    localparam int XFER_BITS  = 2 * FRAME_BITS;   // two frame slots per transfer
    localparam int IDX_W      = $clog2(XFER_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_END
    } bus_state_t;

    // Order of fields is the order on the wire, MSB first.
    typedef struct packed {
        logic                filler;
        logic                rd_flag;
        logic                addr_flag;
        logic                data_flag;
        logic [NIB_BITS-1:0] field;
    } frame_t;

    function automatic frame_t pack_frame(input logic rd, input logic is_addr,
                                          input logic is_data,
                                          input logic [NIB_BITS-1:0] fld);
        frame_t f;
        f.filler    = 1'b1;
        f.rd_flag   = rd;
        f.addr_flag = is_addr;
        f.data_flag = is_data;
        f.field     = fld;
        return f;
    endfunction

endpackage

// File: rtl/rtc3w_phase_timer.sv
// Down-counter that times one bus phase. A restart loads PHASE_CYCLES-1,
// and expire is high in the last cycle of the phase. Assumes PHASE_CYCLES >= 1.
module rtc3w_phase_timer #(
    parameter int PHASE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    // Load at phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= CW'(PHASE_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/rtc3w_frame_gen.sv
// Builds the 16-bit slot stream for one transfer from the request fields.
// Read: address frame followed by all-ones filler (the wire is released then).
// Write: address frame followed by data frame.
module rtc3w_frame_gen
    import rtc3w_pkg::*;
(
    input  logic                 is_write,
    input  logic [NIB_BITS-1:0]  addr,
    input  logic [NIB_BITS-1:0]  wdata,
    output logic [XFER_BITS-1:0] stream
);
    frame_t head_f;
    frame_t tail_f;

    // Select frame contents for the requested direction.
    always_comb begin
        head_f = pack_frame(!is_write, 1'b1, 1'b0, addr);
        if (is_write)
            tail_f = pack_frame(1'b0, 1'b0, 1'b1, wdata);
        else
            tail_f = frame_t'({FRAME_BITS{1'b1}});
        stream = {head_f, tail_f};
    end

endmodule

// File: rtl/rtc3w_rx_nibble.sv
// Shift register that keeps the most recent W sampled bits, first bit
// ending up in the MSB. Cleared at the start of each transfer.
module rtc3w_rx_nibble #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] nib
);
    logic [W-1:0] q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            // Newest bit enters at the LSB.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    q[i] <= 1'b0;
                else if (shift_en)
                    q[i] <= bit_in;
            end
        end else begin : g_up
            // Older bits move toward the MSB.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    q[i] <= 1'b0;
                else if (shift_en)
                    q[i] <= q[i-1];
            end
        end
    end

    assign nib = q;

endmodule

// File: rtl/rtc3w_master.sv
// Three-wire nibble bus master. It accepts one request while idle and runs
// 16 bit slots under one chip-select window. Each slot has three phases of
// PHASE_CYCLES clocks (setup with clock high, clock low, clock high).
// Assumes bus_sdi is already synchronous to clk; the slow bit rate leaves
// it settled well before the sampling cycle.
module rtc3w_master
    import rtc3w_pkg::*;
#(
    parameter int PHASE_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [NIB_BITS-1:0] req_addr,
    input  logic [NIB_BITS-1:0] req_wdata,
    output logic                busy,
    output logic                done,
    output logic [NIB_BITS-1:0] rd_data,
    output logic                bus_ce,
    output logic                bus_sclk,
    output logic                bus_sdo,
    output logic                bus_sdo_en,
    input  logic                bus_sdi
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_BITS - 1);

    bus_state_t           state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [XFER_BITS-1:0] tx_q;
    logic                 rd_q;
    logic                 restart;
    logic                 expire;
    logic                 accept;
    logic                 slot_end;
    logic                 in_reply;
    logic                 active;
    logic                 sample_en;
    logic [XFER_BITS-1:0] stream;

    rtc3w_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expire  (expire)
    );

    rtc3w_frame_gen framer_i (
        .is_write (req_write),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .stream   (stream)
    );

    rtc3w_rx_nibble #(.W(NIB_BITS)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (sample_en),
        .bit_in   (bus_sdi),
        .nib      (rd_data)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign slot_end = (state_q == ST_HIGH) && expire;
    assign active   = (state_q == ST_SETUP) || (state_q == ST_LOW) ||
                      (state_q == ST_HIGH);
    // The upper half of the slots is the second frame.
    assign in_reply  = idx_q[IDX_W-1];
    assign sample_en = (state_q == ST_SETUP) && expire && rd_q && in_reply;

    // Phase sequencing and timer restart at each phase entry.
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SETUP;
                    restart = 1'b1;
                end
            end
            ST_SETUP: begin
                if (expire) begin
                    state_d = ST_LOW;
                    restart = 1'b1;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    state_d = ST_HIGH;
                    restart = 1'b1;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    state_d = (idx_q == LAST_IDX) ? ST_END : ST_SETUP;
                    restart = 1'b1;
                end
            end
            ST_END: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Slot index, transmit shift register and direction capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            tx_q  <= '1;
            rd_q  <= 1'b0;
        end else if (accept) begin
            idx_q <= '0;
            tx_q  <= stream;
            rd_q  <= !req_write;
        end else if (slot_end) begin
            idx_q <= idx_q + 1'b1;
            tx_q  <= {tx_q[XFER_BITS-2:0], 1'b1};
        end
    end

    // Bus and host outputs decoded from registered state.
    always_comb begin
        bus_ce     = active;
        bus_sclk   = (state_q != ST_LOW);
        bus_sdo    = active ? tx_q[XFER_BITS-1] : 1'b1;
        bus_sdo_en = !(active && rd_q && in_reply);
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_END);
    end

endmodule

// File: rtl/rtc3w_master_chk.sv
// Cycle-level protocol checker for rtc3w_master, attached with bind.
module rtc3w_master_chk #(
    parameter int PHASE_CYCLES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic bus_ce,
    input logic bus_sclk,
    input logic bus_sdo,
    input logic bus_sdo_en
);
    logic [15:0] low_run;

    // Length of the current clock-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!bus_sclk)
            low_run <= low_run + 1'b1;
        else
            low_run <= '0;
    end

    assert_idle_clock_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce |-> bus_sclk);

    assert_data_frozen_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sclk && $past(!bus_sclk)) |-> $stable(bus_sdo));

    assert_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_sclk) |-> (low_run == 16'(PHASE_CYCLES)));

    assert_turnaround_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_sdo_en) |-> (bus_ce && bus_sclk));

    assert_drive_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce |-> bus_sdo_en);

    assert_done_with_ce_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_ce && $past(bus_ce)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

bind rtc3w_master rtc3w_master_chk #(.PHASE_CYCLES(PHASE_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .bus_ce     (bus_ce),
    .bus_sclk   (bus_sclk),
    .bus_sdo    (bus_sdo),
    .bus_sdo_en (bus_sdo_en)
);

// File: tb/rtc3w_master_tb_top.sv
// Scoreboard bench: driver pushes expected transfers, a bus slave model
// answers, and the monitor pops and compares at each chip-select fall.
module rtc3w_master_tb_top;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_addr = '0, req_wdata = '0;
    logic bus_sdi = 1'b1;
    logic busy, done, bus_ce, bus_sclk, bus_sdo, bus_sdo_en;
    logic [3:0] rd_data;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    rtc3w_master #(.PHASE_CYCLES(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_ce(bus_ce), .bus_sclk(bus_sclk), .bus_sdo(bus_sdo),
        .bus_sdo_en(bus_sdo_en), .bus_sdi(bus_sdi)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct { bit wr; logic [3:0] a; logic [3:0] d; } item_t;
    item_t sb_q[$];
    logic [3:0] slave_mem[16];
    logic [3:0] model_mem[16];

    // Slave model: captures driven bits, answers reads after the 8th rise.
    int rises, ncap, fell_at;
    logic [15:0] cap;
    logic [7:0] resp;
    always @(posedge bus_ce) begin
        rises = 0; ncap = 0; cap = '0; fell_at = -1; bus_sdi = 1'b1;
    end
    always @(posedge bus_sclk) if (bus_ce === 1'b1) begin
        if (bus_sdo_en) begin cap = {cap[14:0], bus_sdo}; ncap++; end
        rises++;
        if (rises == 8) resp = {~slave_mem[cap[3:0]], slave_mem[cap[3:0]]};
        if (rises >= 8 && rises < 16) bus_sdi = resp[15-rises];
    end
    always @(negedge bus_sdo_en) if (bus_ce === 1'b1) fell_at = rises;

    // Monitor: pop expected item and compare the observed frames.
    always @(negedge bus_ce) if (rst_n) begin
        item_t e;
        if (sb_q.size() == 0) check(0, "R9", "unexpected transfer", 1, 0);
        else begin
            e = sb_q.pop_front();
            check(rises == 16, "R8", "clock pulses in window", rises, 16);
            if (e.wr) begin
                check(ncap == 16, "R4", "driven bits", ncap, 16);
                check(cap[15:8] == {4'b1010, e.a}, "R4", "address frame", cap[15:8], {4'b1010, e.a});
                check(cap[7:0] == {4'b1001, e.d}, "R2", "data frame", cap[7:0], {4'b1001, e.d});
                check(fell_at == -1, "R7", "write turnaround", fell_at, -1);
                slave_mem[cap[11:8]] = cap[3:0];
            end else begin
                check(ncap == 8, "R3", "driven bits", ncap, 8);
                check(cap[7:0] == {4'b1110, e.a}, "R3", "read frame", cap[7:0], {4'b1110, e.a});
                check(fell_at == 8, "R7", "read turnaround point", fell_at, 8);
            end
        end
    end

    // Timing monitor: clock low width and data setup before each fall.
    logic prev_sclk = 1'b1, prev_sdo = 1'b1;
    int low_run = 0, stable_run = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sclk = 1'b1; prev_sdo = 1'b1; low_run = 0; stable_run = 100;
        end else begin
            if (prev_sclk && !bus_sclk)
                check(stable_run >= DIV, "R5", "setup before fall", stable_run, DIV);
            if (!prev_sclk && bus_sclk)
                check(low_run == DIV, "R5", "low width", low_run, DIV);
            low_run = bus_sclk ? 0 : low_run + 1;
            stable_run = (bus_sdo != prev_sdo) ? 1 : stable_run + 1;
            prev_sclk = bus_sclk; prev_sdo = bus_sdo;
        end
    end

    task automatic check_idle_outputs(input string tag);
        check(bus_ce == 0 && bus_sclk == 1 && bus_sdo == 1 && bus_sdo_en == 1,
              "R1", {tag, " bus idle"}, {bus_ce, bus_sclk, bus_sdo, bus_sdo_en}, 4'b0111);
        check(busy == 0 && done == 0, "R1", {tag, " host idle"}, {busy, done}, 0);
    endtask

    // Driver: push expectation, issue request, wait for done.
    task automatic run_txn(input bit wr, input logic [3:0] a, input logic [3:0] d,
                           input bit poke);
        item_t it;
        int cycles;
        it.wr = wr; it.a = a; it.d = d;
        sb_q.push_back(it);
        if (wr) model_mem[a] = d;
        @(negedge clk);
        check(busy == 0, "R10", "idle before request", busy, 0);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        cycles = 1;
        while (!done) begin
            @(negedge clk);
            cycles++;
            if (poke && cycles == 20) begin
                req_valid = 1; req_write = !wr; req_addr = ~a; req_wdata = ~d;
            end
            if (poke && cycles == 23) req_valid = 0;
        end
        check(cycles == 48*DIV + 1, "R10", "latency", cycles, 48*DIV + 1);
        check(bus_ce == 0, "R10", "ce low with done", bus_ce, 0);
        if (!wr) check(rd_data == model_mem[a], "R6", "read data", rd_data, model_mem[a]);
        @(negedge clk);
        check(done == 0 && busy == 0, "R10", "pulse ends", {done, busy}, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            slave_mem[i] = 4'(i ^ 5); model_mem[i] = 4'(i ^ 5);
        end
        repeat (3) @(negedge clk);
        check_idle_outputs("in reset");
        rst_n = 1;
        repeat (2) @(negedge clk);
        check_idle_outputs("after reset");

        run_txn(1, 4'h3, 4'h9, 0);
        run_txn(1, 4'h0, 4'h0, 0);
        run_txn(1, 4'hF, 4'hF, 0);
        run_txn(1, 4'hA, 4'h5, 0);
        run_txn(0, 4'h3, 4'h0, 0);
        run_txn(0, 4'h0, 4'h0, 0);
        run_txn(0, 4'hF, 4'h0, 0);
        run_txn(0, 4'hA, 4'h0, 0);
        run_txn(0, 4'h7, 4'h0, 0);   // R3 unwritten register

        // R9: stray requests while busy must not start a transfer
        run_txn(1, 4'h6, 4'hC, 1);
        run_txn(0, 4'h6, 4'h0, 1);
        repeat (60*DIV) @(negedge clk);
        check(busy == 0 && bus_ce == 0, "R9", "no extra transfer", {busy, bus_ce}, 0);
        check(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 0);

        // R1: reset in the middle of a read
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 4'h2;
        @(negedge clk);
        req_valid = 0;
        repeat (30) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        check_idle_outputs("mid-transfer reset");
        rst_n = 1;
        @(negedge clk);
        run_txn(0, 4'hF, 4'h0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule